// File: doc/BRIEF.md
# Prioritized Interrupt and Trap Vector Unit

This unit decides which of nine maskable interrupt requests is served next and produces the low byte of the pointer into the interrupt vector table. Two requests come from external pins and each has an enable bit in a control register. The other seven come from on-chip peripherals, which gate their own requests. A fixed priority order picks the winner. The vector byte is built from a 3-bit group base that software can move in 32-byte steps, followed by a 5-bit code for the winning source. The code is always even.

The same control register holds a sticky trap flag, which hardware sets when an illegal opcode is decoded, and a read-only flag that records whether the second or the third opcode byte caused the fault. While the trap flag is set, no maskable interrupt is offered to the core. On the rising edge of the acknowledge input, the vector of the current winner is captured. It then holds steady for as long as acknowledge stays high.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, the control register reads 0x01 (trap 0, fault-byte flag 0, only bit 0 of the enables set), the base register reads 0x00, `irq_pending` is 0 and `vec_out` is 0x00.
- R2: Priority, from highest to lowest, is `ext_req[0]`, `ext_req[1]`, then `int_req[0]` through `int_req[6]`. Among the requests that are active and enabled, the one with the highest priority wins.
- R3: The source at priority position k (0 for the highest) gets the 5-bit code 2*k. This gives codes 0x00 to 0x10, and bit 0 of the vector is always 0.
- R4: Writing the base register (`reg_sel`=1) stores `reg_wdata[7:5]` as vector bits [7:5]. Bits [4:0] of that register read back as 0.
- R5: Control bit 1 enables `ext_req[0]` and control bit 2 enables `ext_req[1]`, with 1 meaning enabled. A disabled external request never raises `irq_pending`. Internal requests have no enable bit here.
- R6: Control bit 7 is the trap flag. An `illegal_op` pulse sets it in the next cycle. Writing 0 to bit 7 clears it, and writing 1 to bit 7 leaves it unchanged.
- R7: Control bit 6 takes the value of `fault_third` on each `illegal_op` pulse (0 for the second byte, 1 for the third). Register writes do not change it.
- R8: While the trap flag is 1, `irq_pending` is 0 whatever requests are active.
- R9: In the cycle after `ack` is first seen high, `vec_out` shows the vector of the winner at that edge. It then keeps that value while `ack` stays high, even if requests change.
- R10: When `illegal_op` and a write that clears the trap flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 2 | External interrupt requests, bit 0 has the highest priority |
| int_req | input | 7 | Peripheral requests, already gated by each peripheral |
| illegal_op | input | 1 | One-cycle pulse when an illegal opcode is decoded |
| fault_third | input | 1 | 1 if the faulting byte was the third opcode byte |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the base register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| ack | input | 1 | Interrupt acknowledge, level |
| irq_pending | output | 1 | An enabled maskable request is waiting |
| trap_active | output | 1 | Trap flag |
| vec_out | output | 8 | Captured vector low byte |

## Verification
Two things can happen in the same cycle: the hardware setting the trap flag on an illegal opcode, and a software write that clears it. The bench drives `illegal_op` and a clearing write to the control register on the same clock edge. It then reads the register back and expects bit 7 set and bit 6 equal to the new `fault_third`. The bench also checks that `irq_pending` stays low while active requests are present, because a trap outranks every interrupt.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int N_EXT  = 2,
  parameter int N_INT  = 7,
  parameter int DW     = 8,
  parameter int BASE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_req,
  input  logic [N_INT-1:0]  int_req,
  input  logic              illegal_op,
  input  logic              fault_third,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              ack,
  output logic              irq_pending,
  output logic              trap_active,
  output logic [DW-1:0]     vec_out
);
  localparam int N_SRC  = N_EXT + N_INT;
  localparam int IDX_W  = $clog2(N_SRC);
  localparam int CODE_W = DW - BASE_W;

  logic              trap_q, ufo_q, ack_q;
  logic [N_EXT:0]    mask_q;
  logic [BASE_W-1:0] base_q;
  logic [DW-1:0]     vec_q;
  logic [N_SRC-1:0]  req;
  logic [IDX_W-1:0]  win;
  logic [DW-1:0]     vec_now;

  assign req = {int_req, ext_req & mask_q[N_EXT:1]};

  always_comb begin
    win = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (req[i]) win = IDX_W'(i);
  end

  assign vec_now     = {base_q, CODE_W'({win, 1'b0})};
  assign irq_pending = (|req) & ~trap_q;
  assign trap_active = trap_q;
  assign vec_out     = vec_q;

  wire ctl_wr  = reg_wr & ~reg_sel;
  wire base_wr = reg_wr & reg_sel;

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata[DW-1 -: BASE_W] = base_q;
    end else begin
      reg_rdata[DW-1]    = trap_q;
      reg_rdata[DW-2]    = ufo_q;
      reg_rdata[N_EXT:0] = mask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
      ufo_q  <= 1'b0;
      mask_q <= (N_EXT+1)'(1);
      base_q <= '0;
      ack_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (ctl_wr)  mask_q <= reg_wdata[N_EXT:0];
      if (base_wr) base_q <= reg_wdata[DW-1 -: BASE_W];
      if (illegal_op) begin
        trap_q <= 1'b1;
        ufo_q  <= fault_third;
      end else if (ctl_wr && !reg_wdata[DW-1]) begin
        trap_q <= 1'b0;
      end
      ack_q <= ack;
      if (ack && !ack_q) vec_q <= vec_now;
    end
  end
endmodule

module irq_vector_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          illegal_op,
  input logic          fault_third,
  input logic          ack,
  input logic          irq_pending,
  input logic          trap_q,
  input logic          ufo_q,
  input logic [DW-1:0] vec_out
);
  a_r6_trap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> trap_q);
  a_r6_no_self_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!illegal_op && !trap_q) |=> !trap_q);
  a_r7_fault_byte: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> (ufo_q == $past(fault_third)));
  a_r8_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> !irq_pending);
  a_r9_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(ack)) |=> (!ack || $stable(vec_out)));
endmodule

bind irq_vector_unit irq_vector_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .illegal_op(illegal_op), .fault_third(fault_third),
  .ack(ack), .irq_pending(irq_pending), .trap_q(trap_q), .ufo_q(ufo_q),
  .vec_out(vec_out)
);

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] ext_req = '0;
  logic [6:0] int_req = '0;
  logic illegal_op = 0, fault_third = 0, reg_wr = 0, reg_sel = 0, ack = 0;
  logic [7:0] reg_wdata = '0, reg_rdata, vec_out;
  logic irq_pending, trap_active;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vector_unit u_irq_vector_unit (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .int_req(int_req),
    .illegal_op(illegal_op), .fault_third(fault_third), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack(ack),
    .irq_pending(irq_pending), .trap_active(trap_active), .vec_out(vec_out)
  );

  // {enables[2:0], base[2:0], ext[1:0], int[6:0], pending, vector}
  localparam logic [23:0] TBL [13] = '{
    {3'b111, 3'd0, 2'b01, 7'h00, 1'b1, 8'h00},
    {3'b111, 3'd0, 2'b10, 7'h00, 1'b1, 8'h02},
    {3'b111, 3'd0, 2'b11, 7'h7F, 1'b1, 8'h00},
    {3'b001, 3'd0, 2'b11, 7'h04, 1'b1, 8'h08},
    {3'b001, 3'd1, 2'b00, 7'h40, 1'b1, 8'h30},
    {3'b011, 3'd7, 2'b11, 7'h00, 1'b1, 8'hE0},
    {3'b101, 3'd2, 2'b11, 7'h00, 1'b1, 8'h42},
    {3'b000, 3'd4, 2'b11, 7'h30, 1'b1, 8'h8C},
    {3'b000, 3'd0, 2'b00, 7'h02, 1'b1, 8'h06},
    {3'b000, 3'd0, 2'b11, 7'h00, 1'b0, 8'h00},
    {3'b000, 3'd3, 2'b00, 7'h01, 1'b1, 8'h64},
    {3'b000, 3'd5, 2'b00, 7'h08, 1'b1, 8'hAA},
    {3'b000, 3'd6, 2'b00, 7'h20, 1'b1, 8'hCE}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(bit sel, output logic [7:0] d);
    reg_sel = sel; #1; d = reg_rdata;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rd(0, r); chk("R1 control", r, 8'h01);
    rd(1, r); chk("R1 base", r, 8'h00);
    chk("R1 pending", irq_pending, 0);
    chk("R1 vector", vec_out, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 13; i++) begin
      // R2 priority, R3 codes, R4 base, R5 enables
      wr(0, {5'b0, TBL[i][23:21]});
      wr(1, {TBL[i][20:18], 5'b0});
      ext_req = TBL[i][17:16]; int_req = TBL[i][15:9];
      #1;
      chk("R5/R2 pending", irq_pending, TBL[i][8]);
      if (TBL[i][8]) begin
        ack = 1;
        @(negedge clk);
        chk("R2/R3/R4 vector", vec_out, TBL[i][7:0]);
        ext_req = 2'b11; int_req = 7'h7F;
        @(negedge clk);
        chk("R9 hold", vec_out, TBL[i][7:0]);
        ack = 0;
      end
      ext_req = '0; int_req = '0;
      @(negedge clk);
    end

    wr(1, 8'hFF);
    rd(1, r); chk("R4 low bits zero", r, 8'hE0);

    // R6 / R7
    wr(0, 8'h07);
    illegal_op = 1; fault_third = 1;
    @(negedge clk);
    illegal_op = 0; fault_third = 0;
    rd(0, r); chk("R6/R7 trap set", r, 8'hC7);
    chk("R6 trap_active", trap_active, 1);
    ext_req = 2'b11; int_req = 7'h7F; #1;
    chk("R8 blocked", irq_pending, 0);
    wr(0, 8'h07);
    rd(0, r); chk("R6/R7 cleared, fault flag kept", r, 8'h47);
    chk("R8 released", irq_pending, 1);
    wr(0, 8'hC7);
    rd(0, r); chk("R6 write one ignored", r, 8'h47);
    chk("R6 trap_active stays low", trap_active, 0);

    // R10: set and clear in the same cycle
    wr(0, 8'hC7);
    illegal_op = 1; fault_third = 0;
    reg_wr = 1; reg_sel = 0; reg_wdata = 8'h07;
    @(negedge clk);
    illegal_op = 0; reg_wr = 0;
    rd(0, r); chk("R10 set wins", r, 8'h87);
    chk("R10 pending held off", irq_pending, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule